// File: doc/BRIEF.md
# Looping Pulse-Train Transmitter

This block drives a single output pin from a short program of pulse items held in a local item memory. Each item is one output level plus a hold time in clock cycles. A start strobe plays the items in address order until it meets an end marker. In single-shot mode the channel then goes idle. In continuous mode it jumps back to address 0 with no gap and replays the program. This repeats until a programmed number of rounds has been sent, or until a stop strobe arrives.

After the channel stops, it must park the pin at a well-defined idle level. After an automatic stop, that level comes from the end-marker item that ended the last round. It is never the level of the item the pointer has wrapped back to. A control bit can instead pin the idle level to a value held in a register. Software loads the item memory through a write port and sets the mode through a small register write port. A one-cycle completion pulse and a busy flag report progress.

Top module: `pulse_loop_tx`

## Requirements
- R1: After reset, `tx_out`, `busy` and `done` are 0.
- R2: An item is 16 bits, with bit 15 the level and bits 14:0 the duration. A start strobe sampled while idle raises `busy` and drives item 0's level on `tx_out` from the next cycle. Each item with nonzero duration D holds its level for exactly D cycles, and the items play in increasing address order.
- R3: An item whose duration is 0 is an end marker that closes a round. With control bit 0 (continuous) clear, the channel stops at the first end marker. `busy` falls and `done` is high for exactly one cycle.
- R4: With continuous set, the item after an end marker is item 0, with no extra cycle. A nonzero loop count (register address 1) stops the channel with a `done` pulse once that many rounds are complete.
- R5: After an automatic stop with override clear, `tx_out` is the level bit of the end marker that closed the final round, even when item 0 has the other level.
- R6: With control bit 1 (idle override) set, the idle level is control bit 2. This holds after every stop and also while idle, where the pin follows that bit within three cycles of a register write.
- R7: With continuous set and loop count 0, the channel runs until a stop strobe. A stop strobe while busy lets the current item finish, and stops at that item's end with no `done` pulse. The idle level is then the override value if enabled, otherwise the level of the most recently written end-marker item.
- R8: A start strobe while busy does not restart or alter playback. A stop strobe while idle has no effect on the next run.
- R9: If item 0 is an end marker, a start strobe leaves `busy` low, pulses `done` on the next cycle and parks `tx_out` by the R5/R6 rule.
- R10: `tx_out` is registered and changes only at item boundaries or at a stop. Within an item it is constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address: 0 control, 1 loop count |
| cfg_wdata | input | 16 | Register write data |
| mem_we | input | 1 | Item memory write enable |
| mem_addr | input | 6 | Item memory write address |
| mem_wdata | input | 16 | Item to write (bit 15 level, bits 14:0 duration) |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe |
| busy | output | 1 | Channel is playing |
| done | output | 1 | One-cycle pulse at an automatic stop |
| tx_out | output | 1 | Registered output pin |

## Verification
The bench builds the block with its default parameters. These are a 64-item memory and a 16-bit loop count. Loop counts of 0 to 3 and durations of 1 to 6 cycles keep every wrap, every final round and every stop boundary within a few dozen cycles. Programs of zero to eight items reach the empty-program case, single-item rounds and wraps where item 0 and the end marker differ in level. Stop strobes land both mid-item and on the last cycle of an item.

// File: rtl/plt_pkg.sv
package plt_pkg;

    localparam int ITEM_DUR_W = 15;
    localparam int ITEM_W     = ITEM_DUR_W + 1;
    localparam int CFG_W      = 16;

    typedef struct packed {
        logic                  lvl;
        logic [ITEM_DUR_W-1:0] dur;
    } item_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic ovr_lvl;
        logic ovr_en;
        logic cont;
    } ctrl_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_LOOP = 2'd1;

endpackage

// File: rtl/plt_cfg_regs.sv
module plt_cfg_regs
    import plt_pkg::*;
#(
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [CFG_W-1:0]  wdata,
    output ctrl_t             ctrl,
    output logic [LOOP_W-1:0] loop_cnt
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [LOOP_W-1:0] cnt;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && addr == REG_CTRL) begin
            cfg_d.ctrl.cont    = wdata[0];
            cfg_d.ctrl.ovr_en  = wdata[1];
            cfg_d.ctrl.ovr_lvl = wdata[2];
        end
        if (we && addr == REG_LOOP) begin
            cfg_d.cnt = wdata[LOOP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl     = cfg_q.ctrl;
    assign loop_cnt = cfg_q.cnt;

    AST_LOOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == REG_LOOP) |=> loop_cnt == $past(wdata[LOOP_W-1:0])); // R4

endmodule

// File: rtl/plt_item_mem.sv
module plt_item_mem
    import plt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  item_t                  wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output item_t [NRD-1:0]        rdata,
    output logic                   mark_lvl
);

    item_t mem_d [DEPTH];
    item_t mem_q [DEPTH];
    logic  mark_d, mark_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        mark_d = mark_q;
        if (we) begin
            mem_d[waddr] = wdata;
            if (wdata.dur == '0) mark_d = wdata.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            mark_q <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            mark_q <= mark_d;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem_q[raddr[r]];
    end

    assign mark_lvl = mark_q;

    AST_MARK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata.dur == '0) |=> mark_lvl == $past(wdata.lvl)); // R7

endmodule

// File: rtl/plt_seq_core.sv
module plt_seq_core
    import plt_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LOOP_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              cont,
    input  logic [LOOP_W-1:0] loop_cnt,
    input  logic              mark_lvl,
    input  item_t             item_a,
    input  item_t             item_z,
    output logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic              done,
    output logic              in_idle,
    output logic              load_play,
    output logic              play_lvl,
    output logic              stopping,
    output logic              stop_lvl
);

    localparam logic [ITEM_DUR_W-1:0] DUR_ONE = ITEM_DUR_W'(1);

    typedef struct packed {
        seq_st_e               st;
        logic [AW-1:0]         ptr;
        logic [ITEM_DUR_W-1:0] timer;
        logic [LOOP_W-1:0]     rounds;
        logic                  stop_pend;
        logic                  done;
    } seq_s;

    seq_s              s_d, s_q;
    logic              bnd;
    logic              halt_req;
    logic              last_round;
    logic [LOOP_W-1:0] rbase;
    logic [LOOP_W-1:0] rnext;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        load_play  = 1'b0;
        play_lvl   = 1'b0;
        stopping   = 1'b0;
        stop_lvl   = 1'b0;
        rd_addr    = (s_q.st == ST_IDLE) ? '0 : s_q.ptr + 1'b1;
        bnd        = (s_q.st == ST_IDLE) ? start : (s_q.timer == DUR_ONE);
        halt_req   = (s_q.st == ST_PLAY) && (s_q.stop_pend || stop);
        rbase      = (s_q.st == ST_IDLE) ? '0 : s_q.rounds;
        rnext      = rbase + 1'b1;
        last_round = !cont || (loop_cnt != '0 && rnext == loop_cnt) || (item_z.dur == '0);

        if (s_q.st == ST_PLAY) begin
            s_d.stop_pend = s_q.stop_pend | stop;
            s_d.timer     = s_q.timer - 1'b1;
        end

        if (bnd) begin
            if (halt_req) begin
                s_d.st        = ST_IDLE;
                s_d.stop_pend = 1'b0;
                s_d.timer     = '0;
                stopping      = 1'b1;
                stop_lvl      = mark_lvl;
            end else if (item_a.dur != '0) begin
                s_d.st     = ST_PLAY;
                s_d.ptr    = rd_addr;
                s_d.timer  = item_a.dur;
                s_d.rounds = rbase;
                load_play  = 1'b1;
                play_lvl   = item_a.lvl;
            end else if (last_round) begin
                s_d.st        = ST_IDLE;
                s_d.stop_pend = 1'b0;
                s_d.timer     = '0;
                s_d.done      = 1'b1;
                stopping      = 1'b1;
                stop_lvl      = item_a.lvl;
            end else begin
                s_d.st     = ST_PLAY;
                s_d.ptr    = '0;
                s_d.timer  = item_z.dur;
                s_d.rounds = rnext;
                load_play  = 1'b1;
                play_lvl   = item_z.lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy    = (s_q.st == ST_PLAY);
    assign in_idle = (s_q.st == ST_IDLE);
    assign done    = s_q.done;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && s_q.timer > DUR_ONE) |=> busy); // R8

    AST_STOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> !done); // R7

endmodule

// File: rtl/plt_out_stage.sv
module plt_out_stage
    import plt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_idle,
    input  logic load_play,
    input  logic play_lvl,
    input  logic stopping,
    input  logic stop_lvl,
    input  logic ovr_en,
    input  logic ovr_lvl,
    output logic tx
);

    typedef struct packed {
        logic tx;
        logic park;
    } out_s;

    out_s o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load_play) begin
            o_d.tx = play_lvl;
        end else if (stopping) begin
            o_d.tx   = ovr_en ? ovr_lvl : stop_lvl;
            o_d.park = stop_lvl;
        end else if (in_idle) begin
            o_d.tx = ovr_en ? ovr_lvl : o_q.park;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tx = o_q.tx;

    AST_HOLD_MID_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_idle && !load_play && !stopping) |=> $stable(tx)); // R10

    AST_IDLE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !load_play && !stopping && ovr_en) |=> tx == $past(ovr_lvl)); // R6

    AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (stopping && !ovr_en) |=> tx == $past(stop_lvl)); // R5

endmodule

// File: rtl/pulse_loop_tx.sv
module pulse_loop_tx
    import plt_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LOOP_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_addr,
    input  logic [ITEM_W-1:0] mem_wdata,
    input  logic             start,
    input  logic             stop,
    output logic             busy,
    output logic             done,
    output logic             tx_out
);

    ctrl_t               ctrl;
    logic [LOOP_W-1:0]   loop_cnt;
    logic [1:0][AW-1:0]  rd_addr;
    item_t [1:0]         rd_item;
    logic [AW-1:0]       seq_addr;
    logic                mark_lvl;
    logic                in_idle;
    logic                load_play;
    logic                play_lvl;
    logic                stopping;
    logic                stop_lvl;

    plt_cfg_regs #(.LOOP_W(LOOP_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .ctrl     (ctrl),
        .loop_cnt (loop_cnt)
    );

    assign rd_addr[0] = seq_addr;
    assign rd_addr[1] = '0;

    plt_item_mem #(.DEPTH(DEPTH), .NRD(2)) i_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .waddr    (mem_addr),
        .wdata    (item_t'(mem_wdata)),
        .raddr    (rd_addr),
        .rdata    (rd_item),
        .mark_lvl (mark_lvl)
    );

    plt_seq_core #(.DEPTH(DEPTH), .LOOP_W(LOOP_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .cont      (ctrl.cont),
        .loop_cnt  (loop_cnt),
        .mark_lvl  (mark_lvl),
        .item_a    (rd_item[0]),
        .item_z    (rd_item[1]),
        .rd_addr   (seq_addr),
        .busy      (busy),
        .done      (done),
        .in_idle   (in_idle),
        .load_play (load_play),
        .play_lvl  (play_lvl),
        .stopping  (stopping),
        .stop_lvl  (stop_lvl)
    );

    plt_out_stage i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_idle   (in_idle),
        .load_play (load_play),
        .play_lvl  (play_lvl),
        .stopping  (stopping),
        .stop_lvl  (stop_lvl),
        .ovr_en    (ctrl.ovr_en),
        .ovr_lvl   (ctrl.ovr_lvl),
        .tx        (tx_out)
    );

endmodule

// File: tb/test_pulse_loop_tx.sv
module test_pulse_loop_tx;

    localparam int MAXC = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mem_we = 1'b0;
    logic [5:0]  mem_addr = '0;
    logic [15:0] mem_wdata = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        busy, done, tx_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] img [64];
    bit          mark_lvl = 1'b0;
    bit          m_cont = 1'b0, m_ovr = 1'b0, m_ovl = 1'b0;
    int          m_cnt = 0;

    bit exp_lvl [MAXC];
    int exp_len;
    bit exp_done;
    bit exp_idle;

    always #5 clk = ~clk;

    pulse_loop_tx i_pulse_loop_tx (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .start(start), .stop(stop),
        .busy(busy), .done(done), .tx_out(tx_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_item(input int a, input bit lvl, input int dur);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = 6'(a); mem_wdata = {lvl, 15'(dur)};
        img[a] = {lvl, 15'(dur)};
        if (dur == 0) mark_lvl = lvl;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic wr_cfg(input bit cont, input bit ovr, input bit ovl, input int cnt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = {13'd0, ovl, ovr, cont};
        @(negedge clk);
        cfg_addr = 2'd1; cfg_wdata = 16'(cnt);
        @(negedge clk);
        cfg_we = 1'b0;
        m_cont = cont; m_ovr = ovr; m_ovl = ovl; m_cnt = cnt;
        repeat (2) @(negedge clk);
    endtask

    // Reference: expected per-cycle level, stop kind and idle level
    task automatic build_expect(input int stop_at);
        int ptr = 0;
        int rounds = 0;
        bit fin = 1'b0;
        exp_len = 0; exp_done = 1'b0; exp_idle = 1'b0;
        while (!fin && exp_len < MAXC) begin
            if (img[ptr][14:0] != 0) begin
                for (int k = 0; k < int'(img[ptr][14:0]); k++) begin
                    exp_lvl[exp_len] = img[ptr][15];
                    exp_len++;
                end
                ptr = (ptr + 1) % 64;
                if (stop_at >= 0 && exp_len - 1 >= stop_at) begin
                    fin = 1'b1; exp_done = 1'b0;
                    exp_idle = m_ovr ? m_ovl : mark_lvl;
                end
            end else begin
                rounds++;
                if (!m_cont || (m_cnt != 0 && rounds == m_cnt) || img[0][14:0] == 0) begin
                    fin = 1'b1; exp_done = 1'b1;
                    exp_idle = m_ovr ? m_ovl : img[ptr][15];
                end else begin
                    ptr = 0;
                end
            end
        end
    endtask

    task automatic run_check(input string wave_req, input string end_req,
                             input int stop_at, input bit start_mid);
        int bad = 0;
        int bad_c = -1;
        build_expect(stop_at);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < exp_len; c++) begin
            if (!busy || tx_out != exp_lvl[c]) begin
                bad++;
                if (bad_c < 0) bad_c = c;
            end
            stop  = (c == stop_at);
            start = start_mid && (c == 1);
            @(negedge clk);
        end
        stop = 1'b0; start = 1'b0;
        check(bad == 0, wave_req, bad_c, -1);
        check(!busy && done == exp_done && tx_out == exp_idle, end_req,
              {busy, done, tx_out}, {1'b0, exp_done, exp_idle});
        @(negedge clk);
        check(!done && !busy && tx_out == exp_idle, "R3 done one cycle",
              {busy, done, tx_out}, {2'b00, exp_idle});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < 64; i++) img[i] = '0;
        repeat (3) @(negedge clk);
        check(tx_out == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset",
              {busy, done, tx_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: single shot
        wr_item(0, 1, 3); wr_item(1, 0, 2); wr_item(2, 1, 1); wr_item(3, 0, 0);
        wr_cfg(0, 0, 0, 0);
        run_check("R2 R10 single-shot wave", "R3 single-shot stop", -1, 0);

        // R4 R5: continuous, idle from marker not item 0
        wr_item(0, 1, 2); wr_item(1, 0, 1); wr_item(2, 0, 0);
        wr_cfg(1, 0, 0, 3);
        run_check("R4 wrap wave", "R5 marker level 0", -1, 0);
        wr_item(0, 0, 2); wr_item(1, 1, 3); wr_item(2, 1, 0);
        wr_cfg(1, 0, 0, 2);
        run_check("R4 wrap wave", "R5 marker level 1", -1, 0);

        // R6: override wins over the marker level
        wr_cfg(1, 1, 0, 2);
        run_check("R4 wave with override", "R6 override idle", -1, 0);
        wr_cfg(0, 1, 1, 0);
        check(tx_out == 1'b1, "R6 idle follows override 1", tx_out, 1);
        wr_cfg(0, 1, 0, 0);
        check(tx_out == 1'b0, "R6 idle follows override 0", tx_out, 0);

        // R7: endless loop ended by stop, idle from last written marker
        wr_item(0, 1, 2); wr_item(1, 0, 3); wr_item(2, 1, 0);
        wr_item(20, 0, 0);
        wr_cfg(1, 0, 0, 0);
        run_check("R7 endless wave", "R7 stop strobe stop", 17, 0);
        run_check("R7 endless wave", "R7 stop on last cycle", 14, 0);

        // R8: start while busy ignored; stop while idle ignored
        wr_item(0, 1, 3); wr_item(1, 0, 2); wr_item(2, 1, 0);
        wr_cfg(1, 0, 0, 2);
        run_check("R8 start while busy", "R8 end after busy start", -1, 1);
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
        run_check("R8 stop while idle", "R8 run after idle stop", -1, 0);

        // R9: empty program
        wr_item(0, 1, 0);
        wr_cfg(1, 0, 0, 3);
        run_check("R9 empty wave", "R9 empty program", -1, 0);

        // Random programs
        for (int it = 0; it < 40; it++) begin
            int n = $urandom_range(0, 8);
            int cnt = $urandom_range(0, 3);
            bit cont = 1'($urandom_range(0, 1));
            int s;
            for (int i = 0; i < n; i++) wr_item(i, 1'($urandom_range(0, 1)), $urandom_range(1, 6));
            wr_item(n, 1'($urandom_range(0, 1)), 0);
            if (cont && cnt == 0) s = $urandom_range(0, 40);
            else if ($urandom_range(0, 3) == 0) s = $urandom_range(0, 20);
            else s = -1;
            wr_cfg(cont, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), cnt);
            run_check("R2 R4 random wave", "R5 R6 R7 random stop", s, 0);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule